// File: doc/BRIEF.md
# Three-Row Window Convolution Sequencer

This block feeds the first convolution layer of an always-on vision pipeline. It keeps the three most recent image rows in a rotating line store that is filled one row at a time through a request/valid handshake. Once three rows are present, it steps a 3×3 window across the interior columns. Each window is shared by a bank of weighted-sum lanes, and every lane applies its own signed 3×3 kernel. After a row set has been swept, one fresh row replaces the oldest stored row in place, and the sweep repeats until the frame's last row has been used.

Each window gets a fixed time slot. During the slot the nine kernel taps are visited in turn, each tap picking one stored row and one column offset, and every lane accumulates one product per cycle. Lane accumulators start from zero in every slot. For each window the block presents the lane sums, the centre row and the centre column. During every sweep it can also emit a one-cycle sensor reset pulse at a programmable point. This pulse splits the pixel exposure so that bright scenes do not saturate.

Top module: `trirow_conv_seq`

## Requirements
- R1: While reset is asserted, and afterwards until `frame_start` is seen, `row_req`, `win_valid` and `exp_rst` are low.
- R2: While `row_req` is high, each cycle with `pix_valid` high stores `pix_data` into the next column of the row being loaded, columns 0 to COLS-1 in order. When `row_req` is low, `pix_valid` and `pix_data` have no effect on any stored pixel or later sum.
- R3: A weight word has its sign in bit MAG_W (1 = subtract) and an unsigned magnitude in bits MAG_W-1:0. Each lane sum equals the signed sum of its nine pixel×magnitude products. The sum is ACC_W bits wide and never wraps, even with all pixels at full scale and all weights at full magnitude of one sign. Nothing carries over from the previous window.
- R4: Tap index t = 3·kr + kc reads the pixel in stored row (newest−2+kr) at column (win_col−1+kc), and uses the lane's weight at index t (the value written with `wt_tap` = t).
- R5: A sweep starts in the cycle after the last pixel of the third or a later row is accepted. Windows go to columns 1 through COLS-2 in ascending order, one every SLOT cycles. For column c, `win_valid` is high for exactly one cycle, at sweep cycle (c−1)·SLOT + 10, counting the first sweep cycle as 0.
- R6: `row_req` goes high in the cycle after `frame_start`. It stays high, with no sweep, until three complete rows are loaded. After each later sweep it rises again for exactly one row, while rows remain.
- R7: After ROWS rows have been loaded and the final sweep ends, `row_req` stays low and the block is idle. `frame_start` has no effect outside the idle state.
- R8: If 1 ≤ `exp_cfg` < (COLS−2)·SLOT, `exp_rst` pulses for one cycle at sweep cycle `exp_cfg` in every sweep. If `exp_cfg` is 0 or at least the sweep length, there is no pulse.
- R9: `wt_we` writes `wt_val` to lane `wt_lane`, tap `wt_tap`, and windows started after the write use the new value. Weights reset to zero.
- R10: When `win_valid` is high, `win_row` is the 0-based index of the centre row of the window, which is the number of rows loaded so far minus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a frame when idle |
| row_req | output | 1 | Block is accepting pixels of a row |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel value, unsigned |
| wt_we | input | 1 | Weight write strobe |
| wt_lane | input | LANE_IW | Lane addressed by a weight write |
| wt_tap | input | 4 | Tap index 0..8 addressed by a weight write |
| wt_val | input | MAG_W+1 | Sign and magnitude of the weight |
| exp_cfg | input | EXP_W | Sweep cycle of the exposure reset pulse, 0 = off |
| exp_rst | output | 1 | Sensor exposure reset pulse |
| win_valid | output | 1 | Window result present |
| win_row | output | ROW_IW | Centre row of the window |
| win_col | output | COL_IW | Centre column of the window |
| lane_sum | output | LANES·ACC_W | Signed lane sums, lane 0 in the low bits |

## Verification
The sums are exercised with four patterns. Pseudo-random pixels with mixed-sign weights that differ per lane and per tap expose any wrong tap-to-row or tap-to-column mapping and any lane crosstalk. A full-scale frame with all weights at maximum positive, then at maximum negative, probes the accumulator width in both directions. A ramp frame with weights that depend on the tap separates column offsets that random data could mask. Pixel strobes arrive with gaps and keep toggling during sweeps and idle time, so a store that takes data out of turn corrupts later sums. The exposure setting covers the off value, an early cycle, the final sweep cycle and a value beyond the sweep, and a stray frame start is issued mid-frame.

// File: rtl/trirow_pkg.sv
package trirow_pkg;
   localparam int KDIM     = 3;
   localparam int KTAPS    = KDIM * KDIM;
   localparam int BUF_ROWS = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SWEEP = 2'd2
   } seq_st_e;

   // modulo-3 advance of a buffered-row slot index
   function automatic logic [1:0] slot_add(input logic [1:0] base, input int step);
      int v;
      v = int'(base) + step;
      while (v >= BUF_ROWS) v = v - BUF_ROWS;
      return 2'(v);
   endfunction
endpackage

// File: rtl/trirow_linebuf.sv
module trirow_linebuf
   import trirow_pkg::*;
#(
   parameter int COLS   = 320,
   parameter int PIX_W  = 8,
   parameter int COL_IW = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_slot,
   input  logic [COL_IW-1:0] wr_col,
   input  logic [PIX_W-1:0]  wr_data,
   input  logic [1:0]        rd_slot,
   input  logic [COL_IW-1:0] rd_col,
   output logic [PIX_W-1:0]  rd_data
);
   logic [PIX_W-1:0] row_out [BUF_ROWS];

   for (genvar r = 0; r < BUF_ROWS; r++) begin : g_row
      logic [PIX_W-1:0] cells [COLS];
      always_ff @(posedge clk) begin
         if (wr_en && wr_slot == 2'(r)) cells[wr_col] <= wr_data;
      end
      assign row_out[r] = cells[rd_col];
   end

   assign rd_data = (rd_slot < 2'(BUF_ROWS)) ? row_out[rd_slot] : '0;

   a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_col) < COLS && wr_slot < 2'(BUF_ROWS)));
   a_r4_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_slot < 2'(BUF_ROWS));
endmodule

// File: rtl/trirow_lane_bank.sv
module trirow_lane_bank
   import trirow_pkg::*;
#(
   parameter int LANES   = 64,
   parameter int PIX_W   = 8,
   parameter int MAG_W   = 4,
   parameter int ACC_W   = PIX_W + MAG_W + 5,
   parameter int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wt_we,
   input  logic [LANE_IW-1:0]       wt_lane,
   input  logic [3:0]               wt_tap,
   input  logic [MAG_W:0]           wt_val,
   input  logic                     acc_clr,
   input  logic                     acc_en,
   input  logic [3:0]               tap,
   input  logic [PIX_W-1:0]         pix,
   output logic [LANES*ACC_W-1:0]   sums
);
   localparam int BOUND = KTAPS * ((1 << PIX_W) - 1) * ((1 << MAG_W) - 1);

   logic [MAG_W:0] wt_q [LANES][KTAPS];
   logic [3:0]     tap_idx;

   assign tap_idx = (int'(tap) < KTAPS) ? tap : 4'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LANES; l++)
            for (int t = 0; t < KTAPS; t++)
               wt_q[l][t] <= '0;
      end else if (wt_we && int'(wt_lane) < LANES && int'(wt_tap) < KTAPS) begin
         wt_q[wt_lane][wt_tap] <= wt_val;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [MAG_W:0]          w_sel;
      logic signed [ACC_W-1:0] term;
      logic signed [ACC_W-1:0] acc_q;

      assign w_sel = wt_q[l][tap_idx];
      assign term  = $signed(ACC_W'(pix) * ACC_W'(w_sel[MAG_W-1:0]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc_q <= '0;
         else if (acc_clr) acc_q <= '0;
         else if (acc_en)  acc_q <= w_sel[MAG_W] ? (acc_q - term) : (acc_q + term);
      end

      assign sums[l*ACC_W +: ACC_W] = acc_q;

      a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         acc_en |=> (acc_q <= ACC_W'(BOUND) && acc_q >= -ACC_W'(BOUND)));
   end
endmodule

// File: rtl/trirow_sequencer.sv
module trirow_sequencer
   import trirow_pkg::*;
#(
   parameter int COLS   = 320,
   parameter int ROWS   = 240,
   parameter int SLOT   = 18,
   parameter int EXP_W  = 16,
   parameter int COL_IW = $clog2(COLS),
   parameter int ROW_IW = $clog2(ROWS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              pix_valid,
   input  logic [EXP_W-1:0]  exp_cfg,
   output logic              row_req,
   output logic              wr_en,
   output logic [1:0]        wr_slot,
   output logic [COL_IW-1:0] wr_col,
   output logic [1:0]        rd_slot,
   output logic [COL_IW-1:0] rd_col,
   output logic [3:0]        tap,
   output logic              acc_clr,
   output logic              acc_en,
   output logic              win_valid,
   output logic [ROW_IW-1:0] win_row,
   output logic [COL_IW-1:0] win_col,
   output logic              exp_rst
);
   localparam int SLOT_W    = $clog2(SLOT);
   localparam int SWEEP_LEN = (COLS - 2) * SLOT;
   localparam int CYC_W     = $clog2(SWEEP_LEN + 1);
   localparam int CMP_W     = (CYC_W > EXP_W) ? CYC_W : EXP_W;
   localparam int EMIT_AT   = KTAPS + 1;

   seq_st_e           st;
   logic [SLOT_W-1:0] s_q;
   logic [COL_IW-1:0] col_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [COL_IW-1:0] incol_q;
   logic [ROW_IW-1:0] rows_q;
   logic [1:0]        wslot_q;
   int                tap_n;
   int                krow;
   int                kcol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         s_q     <= '0;
         col_q   <= '0;
         cyc_q   <= '0;
         incol_q <= '0;
         rows_q  <= '0;
         wslot_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (frame_start) begin
                  st      <= ST_LOAD;
                  rows_q  <= '0;
                  incol_q <= '0;
                  wslot_q <= '0;
               end
            end
            ST_LOAD: begin
               if (pix_valid) begin
                  if (incol_q == COL_IW'(COLS - 1)) begin
                     incol_q <= '0;
                     wslot_q <= slot_add(wslot_q, 1);
                     rows_q  <= rows_q + 1'b1;
                     if (rows_q >= ROW_IW'(BUF_ROWS - 1)) begin
                        st    <= ST_SWEEP;
                        s_q   <= '0;
                        col_q <= COL_IW'(1);
                        cyc_q <= '0;
                     end
                  end else begin
                     incol_q <= incol_q + 1'b1;
                  end
               end
            end
            ST_SWEEP: begin
               cyc_q <= cyc_q + 1'b1;
               if (s_q == SLOT_W'(SLOT - 1)) begin
                  s_q <= '0;
                  if (col_q == COL_IW'(COLS - 2))
                     st <= (rows_q == ROW_IW'(ROWS)) ? ST_IDLE : ST_LOAD;
                  else
                     col_q <= col_q + 1'b1;
               end else begin
                  s_q <= s_q + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // tap stepping: row select follows the rotating oldest-row slot
   always_comb begin
      tap_n = (s_q == '0) ? 0 : int'(s_q) - 1;
      if (tap_n > KTAPS - 1) tap_n = KTAPS - 1;
      krow    = tap_n / KDIM;
      kcol    = tap_n % KDIM;
      rd_slot = slot_add(wslot_q, krow);
      rd_col  = col_q + COL_IW'(kcol) - COL_IW'(1);
      tap     = 4'(tap_n);
   end

   assign row_req   = (st == ST_LOAD);
   assign wr_en     = (st == ST_LOAD) && pix_valid;
   assign wr_slot   = wslot_q;
   assign wr_col    = incol_q;
   assign acc_clr   = (st == ST_SWEEP) && (s_q == '0);
   assign acc_en    = (st == ST_SWEEP) && (s_q != '0) && (int'(s_q) <= KTAPS);
   assign win_valid = (st == ST_SWEEP) && (s_q == SLOT_W'(EMIT_AT));
   assign win_row   = rows_q - ROW_IW'(2);
   assign win_col   = col_q;
   assign exp_rst   = (st == ST_SWEEP) && (exp_cfg != '0) &&
                      (CMP_W'(cyc_q) == CMP_W'(exp_cfg));

   a_r6_three_rows: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> rows_q >= ROW_IW'(BUF_ROWS));
   a_r5_col_range: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (col_q >= COL_IW'(1) && col_q <= COL_IW'(COLS - 2)));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> !win_valid);
   a_r7_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_SWEEP) |-> rows_q == ROW_IW'(ROWS));
   a_r8_exp_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      exp_rst |-> (exp_cfg != '0 && !row_req));
endmodule

// File: rtl/trirow_conv_seq.sv
module trirow_conv_seq
   import trirow_pkg::*;
#(
   parameter int COLS  = 320,
   parameter int ROWS  = 240,
   parameter int LANES = 64,
   parameter int PIX_W = 8,
   parameter int MAG_W = 4,
   parameter int SLOT  = 18,
   parameter int EXP_W = 16,
   localparam int ACC_W   = PIX_W + MAG_W + $clog2(KTAPS) + 1,
   localparam int COL_IW  = $clog2(COLS),
   localparam int ROW_IW  = $clog2(ROWS + 1),
   localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_start,
   output logic                   row_req,
   input  logic                   pix_valid,
   input  logic [PIX_W-1:0]       pix_data,
   input  logic                   wt_we,
   input  logic [LANE_IW-1:0]     wt_lane,
   input  logic [3:0]             wt_tap,
   input  logic [MAG_W:0]         wt_val,
   input  logic [EXP_W-1:0]       exp_cfg,
   output logic                   exp_rst,
   output logic                   win_valid,
   output logic [ROW_IW-1:0]      win_row,
   output logic [COL_IW-1:0]      win_col,
   output logic [LANES*ACC_W-1:0] lane_sum
);
   if (SLOT < KTAPS + 2) begin : g_bad_slot
      $error("SLOT must leave room for nine taps plus clear and emit cycles");
   end
   if (COLS < KDIM || ROWS < BUF_ROWS) begin : g_bad_dims
      $error("frame must be at least 3x3");
   end
   if (LANES < 1 || PIX_W < 1 || MAG_W < 1) begin : g_bad_width
      $error("lane count and widths must be positive");
   end

   logic              wr_en;
   logic [1:0]        wr_slot;
   logic [COL_IW-1:0] wr_col;
   logic [1:0]        rd_slot;
   logic [COL_IW-1:0] rd_col;
   logic [PIX_W-1:0]  rd_pix;
   logic [3:0]        tap;
   logic              acc_clr;
   logic              acc_en;

   trirow_sequencer #(
      .COLS(COLS), .ROWS(ROWS), .SLOT(SLOT), .EXP_W(EXP_W),
      .COL_IW(COL_IW), .ROW_IW(ROW_IW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
      .exp_cfg(exp_cfg), .row_req(row_req), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_col(wr_col), .rd_slot(rd_slot), .rd_col(rd_col), .tap(tap),
      .acc_clr(acc_clr), .acc_en(acc_en), .win_valid(win_valid),
      .win_row(win_row), .win_col(win_col), .exp_rst(exp_rst)
   );

   trirow_linebuf #(
      .COLS(COLS), .PIX_W(PIX_W), .COL_IW(COL_IW)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(wr_col),
      .wr_data(pix_data), .rd_slot(rd_slot), .rd_col(rd_col), .rd_data(rd_pix)
   );

   trirow_lane_bank #(
      .LANES(LANES), .PIX_W(PIX_W), .MAG_W(MAG_W), .ACC_W(ACC_W), .LANE_IW(LANE_IW)
   ) u_lanes (
      .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_lane(wt_lane), .wt_tap(wt_tap),
      .wt_val(wt_val), .acc_clr(acc_clr), .acc_en(acc_en), .tap(tap),
      .pix(rd_pix), .sums(lane_sum)
   );

   a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> !row_req);
endmodule

// File: tb/trirow_conv_seq_bench.sv
module trirow_conv_seq_bench;
   localparam int C  = 8;
   localparam int R  = 5;
   localparam int L  = 4;
   localparam int PW = 8;
   localparam int MW = 4;
   localparam int SL = 12;
   localparam int EW = 16;
   localparam int AW = PW + MW + 5;
   localparam int CW = $clog2(C);
   localparam int RW = $clog2(R + 1);
   localparam int LW = $clog2(L);
   localparam int SW = (C - 2) * SL;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          row_req;
   logic          pix_valid = 1'b0;
   logic [PW-1:0] pix_data = '0;
   logic          wt_we = 1'b0;
   logic [LW-1:0] wt_lane = '0;
   logic [3:0]    wt_tap = '0;
   logic [MW:0]   wt_val = '0;
   logic [EW-1:0] exp_cfg = '0;
   logic          exp_rst;
   logic          win_valid;
   logic [RW-1:0] win_row;
   logic [CW-1:0] win_col;
   logic [L*AW-1:0] lane_sum;

   trirow_conv_seq #(
      .COLS(C), .ROWS(R), .LANES(L), .PIX_W(PW), .MAG_W(MW), .SLOT(SL), .EXP_W(EW)
   ) u_trirow_conv_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_req(row_req),
      .pix_valid(pix_valid), .pix_data(pix_data), .wt_we(wt_we), .wt_lane(wt_lane),
      .wt_tap(wt_tap), .wt_val(wt_val), .exp_cfg(exp_cfg), .exp_rst(exp_rst),
      .win_valid(win_valid), .win_row(win_row), .win_col(win_col), .lane_sum(lane_sum)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   int pmode = 0;
   int drive_on = 0;
   int ramp = 0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference state
   int m_phase = 0;   // 0 idle, 1 loading, 2 sweeping
   int m_rows = 0;
   int m_incol = 0;
   int m_cyc = 0;
   int img [R][C];
   int wts [L][9];

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   function automatic int wdec(input logic [MW:0] v);
      return v[MW] ? -int'(v[MW-1:0]) : int'(v[MW-1:0]);
   endfunction

   initial begin
      for (int l = 0; l < L; l++)
         for (int t = 0; t < 9; t++)
            wts[l][t] = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_rows = 0; m_incol = 0; m_cyc = 0;
      end else begin
         if (wt_we && int'(wt_tap) < 9) wts[wt_lane][wt_tap] = wdec(wt_val);
         case (m_phase)
            0: if (frame_start) begin m_phase = 1; m_rows = 0; m_incol = 0; end
            1: if (pix_valid) begin
                  img[m_rows][m_incol] = int'(pix_data);
                  if (m_incol == C - 1) begin
                     m_incol = 0;
                     m_rows++;
                     if (m_rows >= 3) begin m_phase = 2; m_cyc = 0; end
                  end else m_incol++;
               end
            default: begin
               if (m_cyc == SW - 1) m_phase = (m_rows == R) ? 0 : 1;
               else m_cyc++;
            end
         endcase
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      int ewv;
      int eer;
      int c;
      int s;
      ewv = (m_phase == 2 && (m_cyc % SL) == 10) ? 1 : 0;
      eer = (m_phase == 2 && int'(exp_cfg) != 0 && m_cyc == int'(exp_cfg)) ? 1 : 0;
      chk("R6 row_req", int'(row_req), (m_phase == 1) ? 1 : 0);
      chk("R5 win_valid", int'(win_valid), ewv);
      chk("R8 exp_rst", int'(exp_rst), eer);
      if (ewv == 1) begin
         c = m_cyc / SL + 1;
         chk("R5 win_col", int'(win_col), c);
         chk("R10 win_row", int'(win_row), m_rows - 2);
         for (int l = 0; l < L; l++) begin
            s = 0;
            for (int kr = 0; kr < 3; kr++)
               for (int kc = 0; kc < 3; kc++)
                  s += wts[l][3*kr+kc] * img[m_rows-3+kr][c-1+kc];
            chk("R2/R3/R4/R9 lane_sum", int'($signed(lane_sum[l*AW +: AW])), s);
         end
      end
   end

   // pixel driver: strobes with gaps, active in every phase
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ramp <= ramp + 1;
      pix_valid <= (drive_on != 0) && (lfsr[2:0] != 3'd0);
      case (pmode)
         1:       pix_data <= '1;
         2:       pix_data <= PW'(ramp * 7);
         default: pix_data <= lfsr[PW-1:0];
      endcase
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         n_bad++;
         $display("FAIL R7 watchdog actual=%0d cycles expected=below 50000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic load_weights(input int wmode);
      for (int l = 0; l < L; l++)
         for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            wt_we   = 1'b1;
            wt_lane = LW'(l);
            wt_tap  = 4'(t);
            case (wmode)
               1:       wt_val = {1'b0, 4'd15};
               2:       wt_val = {1'b1, 4'd15};
               3:       wt_val = {(t >= 4), 4'(t + l)};
               default: wt_val = {((l + t) % 2 == 1), 4'((l * 3 + t) % 16)};
            endcase
         end
      @(negedge clk);
      wt_we = 1'b0;
      // out-of-range tap write must be dropped (R9)
      wt_we = 1'b1; wt_tap = 4'd12; wt_val = '1;
      @(negedge clk);
      wt_we = 1'b0;
   endtask

   task automatic run_frame(input int pm, input int wmode, input int cfg, input int stray);
      load_weights(wmode);
      pmode = pm;
      exp_cfg = EW'(cfg);
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk("R6 request after start", int'(row_req), 1);
      if (stray != 0) begin
         repeat (60) @(negedge clk);
         frame_start = 1'b1;      // ignored outside idle (R7)
         @(negedge clk);
         frame_start = 1'b0;
      end
      while (m_phase != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R7 idle after frame", int'(row_req), 0);
      chk("R7 no window after frame", int'(win_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 row_req in reset", int'(row_req), 0);
      chk("R1 win_valid in reset", int'(win_valid), 0);
      rst_n = 1'b1;
      drive_on = 1;
      repeat (5) @(negedge clk);
      chk("R1 idle row_req", int'(row_req), 0);
      chk("R1 idle exp_rst", int'(exp_rst), 0);
      run_frame(0, 0, 5, 0);
      run_frame(1, 1, 0, 0);
      run_frame(1, 2, SW - 1, 0);
      run_frame(2, 3, 200, 1);
      run_frame(0, 0, 37, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule